// File: doc/BRIEF.md
# ADC Calibration Correction Datapath

This block turns a 12-bit unsigned converter code into a reading in microvolts. A code of 4096 steps spans 1.5 V. A 32-bit calibration word carries two trims and a flag that says whether they apply. The first trim is an offset, which is taken off the code. The second is a gain trim, which moves the divisor away from 4096 instead of multiplying the result.

The first accepted conversion after reset copies the trims out of the calibration word. Every later conversion reuses them until the next reset.

A conversion starts with a one-cycle `start_i` while the block is idle. The raw code is registered on that edge. On the next cycle the corrected code is multiplied by the full-scale constant at 48-bit width. The product then goes to a restoring divider that yields one quotient bit per cycle. When the divider finishes, `done_o` pulses for one cycle and `result_o` holds the new value.

Top module: `adc_trim_conv`

## Requirements
- R1: The calibration word is decoded as follows. Bits 9:0 hold the offset field, bits 19:10 hold the gain field and bit 20 is the enable flag. Each correction is its 10-bit field value minus 512, so it ranges from -512 to +511.
- R2: When the enable flag of the captured word is 0, both corrections are zero and the result is raw*1500000/4096, whatever the field bits hold.
- R3: The calibration word is sampled only on the first start accepted after reset. Changes to `cal_word_i` afterwards leave every later result unchanged.
- R4: The result is (raw - offset correction) * 1500000 / (4096 + gain correction), truncated toward zero.
- R5: If the raw code is below the offset correction, the result is 0 instead of a wrapped value. A raw code equal to the offset correction also gives 0.
- R6: `done_o` is high for exactly one cycle per accepted conversion. `result_o` keeps its value from that pulse until the next pulse.
- R7: A start is accepted only when `busy_o` is 0. `busy_o` rises on the accepting edge and stays high until the edge on which `done_o` rises. A start raised while busy produces no result and does not disturb the running one.
- R8: While `rst` is high, `busy_o`, `done_o` and `result_o` are 0 and any conversion in progress is dropped. The next accepted start after reset captures the calibration word again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Conversion request, accepted while idle |
| raw_i | input | 12 | Unsigned raw converter code, registered on the accepting edge |
| cal_word_i | input | 32 | Calibration word, sampled once after reset |
| busy_o | output | 1 | A conversion is in progress |
| done_o | output | 1 | One-cycle pulse: result_o is valid |
| result_o | output | 32 | Corrected reading in microvolts |

## Verification
The hardest situation to reach from the ports is a calibration capture that must happen again. The trims are latched only once, so a single run can exercise at most one calibration word. The stimulus therefore goes through several resets, one of them in the middle of a running division. After each reset it supplies a fresh word, then changes `cal_word_i` on later starts to show that the change has no effect. It also sets the offset field to its extremes so that the saturation to zero and the exact-zero boundary both occur, and it raises `start_i` in the middle of a division to show that the request is dropped.

// File: rtl/adc_trim_pkg.sv
package adc_trim_pkg;

    localparam int RAW_W    = 12;
    localparam int CAL_W    = 32;
    localparam int FIELD_W  = 10;
    localparam int OFF_LSB  = 0;
    localparam int GAIN_LSB = 10;
    localparam int EN_BIT   = 20;
    localparam int BIAS     = 512;
    localparam int CORR_W   = FIELD_W + 1;
    localparam int STEPS    = 4096;
    localparam int FS_UV    = 1500000;
    localparam int PROD_W   = 48;
    localparam int DIFF_W   = RAW_W + 2;
    localparam int MAG_W    = RAW_W + 1;
    localparam int DVS_W    = RAW_W + 1;
    localparam int RES_W    = 32;
    localparam int DVS_MIN  = STEPS - BIAS;
    localparam int DVS_MAX  = STEPS + BIAS - 1;

    typedef struct packed {
        logic signed [CORR_W-1:0] off;
        logic signed [CORR_W-1:0] gain;
    } trim_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_RUN  = 2'd2
    } conv_state_e;

    function automatic logic signed [CORR_W-1:0] field_to_corr(input logic [FIELD_W-1:0] f);
        return $signed({1'b0, f}) - CORR_W'(BIAS);
    endfunction

endpackage

// File: rtl/trim_capture.sv
module trim_capture
    import adc_trim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CAL_W-1:0] cal_word_i,
    output trim_t            trim_o,
    output logic             have_o
);
    trim_t trim_q;
    trim_t trim_d;
    logic  have_q;

    always_comb begin
        if (cal_word_i[EN_BIT]) begin
            trim_d.off  = field_to_corr(cal_word_i[OFF_LSB  +: FIELD_W]);
            trim_d.gain = field_to_corr(cal_word_i[GAIN_LSB +: FIELD_W]);
        end else begin
            trim_d.off  = '0;
            trim_d.gain = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trim_q <= '0;
            have_q <= 1'b0;
        end else if (load_i && !have_q) begin
            trim_q <= trim_d;
            have_q <= 1'b1;
        end
    end

    assign trim_o = trim_q;
    assign have_o = have_q;
endmodule

// File: rtl/trim_scaler.sv
module trim_scaler
    import adc_trim_pkg::*;
(
    input  logic [RAW_W-1:0]  raw_i,
    input  trim_t             trim_i,
    output logic [PROD_W-1:0] dividend_o,
    output logic [DVS_W-1:0]  divisor_o,
    output logic              under_o
);
    localparam logic [PROD_W-1:0] FS_VEC = PROD_W'(FS_UV);
    localparam logic signed [DIFF_W-1:0] STEPS_S = DIFF_W'(STEPS);

    logic signed [DIFF_W-1:0] diff;
    logic signed [DIFF_W-1:0] dvs_full;
    logic [MAG_W-1:0]         mag;
    logic [PROD_W-1:0]        mag_ext;

    always_comb begin
        diff     = $signed({2'b00, raw_i})
                 - $signed({{(DIFF_W-CORR_W){trim_i.off[CORR_W-1]}}, trim_i.off});
        under_o  = diff[DIFF_W-1];
        mag      = under_o ? '0 : diff[MAG_W-1:0];
        mag_ext  = {{(PROD_W-MAG_W){1'b0}}, mag};
        dividend_o = mag_ext * FS_VEC;
        dvs_full = STEPS_S
                 + $signed({{(DIFF_W-CORR_W){trim_i.gain[CORR_W-1]}}, trim_i.gain});
        divisor_o = dvs_full[DVS_W-1:0];
    end
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
    parameter int DVD_W = 48,
    parameter int DVS_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [DVD_W-1:0] dividend_i,
    input  logic [DVS_W-1:0] divisor_i,
    output logic             busy_o,
    output logic             last_o,
    output logic             done_o,
    output logic [DVD_W-1:0] quot_o
);
    localparam int CNT_W = $clog2(DVD_W + 1);

    logic             run_q;
    logic             done_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DVD_W-1:0] quo_q;
    logic [DVD_W-1:0] res_q;
    logic [DVS_W:0]   rem_q;
    logic [DVS_W-1:0] dvs_q;

    logic [DVS_W:0]   shifted;
    logic [DVS_W+1:0] trial;
    logic             fits;

    always_comb begin
        shifted = {rem_q[DVS_W-1:0], quo_q[DVD_W-1]};
        trial   = {1'b0, shifted} - {2'b00, dvs_q};
        fits    = !trial[DVS_W+1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            quo_q  <= '0;
            res_q  <= '0;
            rem_q  <= '0;
            dvs_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (start_i && !run_q) begin
                quo_q <= dividend_i;
                rem_q <= '0;
                dvs_q <= divisor_i;
                cnt_q <= CNT_W'(DVD_W - 1);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= fits ? trial[DVS_W:0] : shifted;
                quo_q <= {quo_q[DVD_W-2:0], fits};
                if (cnt_q == '0) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                    res_q  <= {quo_q[DVD_W-2:0], fits};
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign busy_o = run_q;
    assign last_o = run_q && (cnt_q == '0);
    assign done_o = done_q;
    assign quot_o = res_q;
endmodule

// File: rtl/adc_trim_conv.sv
module adc_trim_conv
    import adc_trim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [RAW_W-1:0] raw_i,
    input  logic [CAL_W-1:0] cal_word_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o
);
    conv_state_e       state_q;
    logic [RAW_W-1:0]  raw_q;
    logic              accept;
    trim_t             trim_s;
    logic              trim_have;
    logic [PROD_W-1:0] dividend;
    logic [DVS_W-1:0]  divisor;
    logic              under;
    logic              div_start;
    logic              div_busy;
    logic              div_last;
    logic              div_done;
    logic [PROD_W-1:0] div_quot;

    assign accept    = start_i && (state_q == ST_IDLE);
    assign div_start = (state_q == ST_PREP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            raw_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    raw_q   <= raw_i;
                    state_q <= ST_PREP;
                end
                ST_PREP: state_q <= ST_RUN;
                ST_RUN:  if (div_last) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    trim_capture cap_i (
        .clk        (clk),
        .rst        (rst),
        .load_i     (accept),
        .cal_word_i (cal_word_i),
        .trim_o     (trim_s),
        .have_o     (trim_have)
    );

    trim_scaler scl_i (
        .raw_i      (raw_q),
        .trim_i     (trim_s),
        .dividend_o (dividend),
        .divisor_o  (divisor),
        .under_o    (under)
    );

    seq_divider #(
        .DVD_W (PROD_W),
        .DVS_W (DVS_W)
    ) div_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (div_start),
        .dividend_i (dividend),
        .divisor_i  (divisor),
        .busy_o     (div_busy),
        .last_o     (div_last),
        .done_o     (div_done),
        .quot_o     (div_quot)
    );

    assign busy_o   = (state_q != ST_IDLE);
    assign done_o   = div_done;
    assign result_o = div_quot[RES_W-1:0];
endmodule

// File: rtl/adc_trim_conv_chk.sv
module adc_trim_conv_chk
    import adc_trim_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy_o,
    input logic             done_o,
    input logic [RES_W-1:0] result_o,
    input logic             trim_have,
    input trim_t            trim_s,
    input logic             div_start,
    input logic [DVS_W-1:0] divisor,
    input logic             under,
    input logic             div_busy
);
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(result_o));

    // R3
    trim_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (trim_have && $past(trim_have)) |-> $stable(trim_s));

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (busy_o || done_o));

    // R7
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(busy_o));

    // R4
    divisor_range_chk: assert property (@(posedge clk) disable iff (rst)
        div_start |-> (divisor >= DVS_W'(DVS_MIN) && divisor <= DVS_W'(DVS_MAX)));

    // R1
    trim_used_chk: assert property (@(posedge clk) disable iff (rst)
        div_start |-> trim_have);

    // R5
    under_idle_div_chk: assert property (@(posedge clk) disable iff (rst)
        (div_start && under) |=> div_busy);
endmodule

bind adc_trim_conv adc_trim_conv_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .result_o  (result_o),
    .trim_have (trim_have),
    .trim_s    (trim_s),
    .div_start (div_start),
    .divisor   (divisor),
    .under     (under),
    .div_busy  (div_busy)
);

// File: tb/adc_trim_conv_tb_top.sv
module adc_trim_conv_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [11:0] raw = '0;
    logic [31:0] cal = '0;
    logic        busy;
    logic        done;
    logic [31:0] result;

    int n_tests = 0;
    int n_fail  = 0;
    longint exp_q[$];
    string  tag_q[$];
    bit          cap_ok = 1'b0;
    logic [31:0] cap_word = '0;
    longint      last_exp = 0;
    logic        prev_done = 1'b0;

    always #10 clk = ~clk;

    adc_trim_conv dut_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .raw_i      (raw),
        .cal_word_i (cal),
        .busy_o     (busy),
        .done_o     (done),
        .result_o   (result)
    );

    function automatic logic [31:0] mkcal(input bit en, input int gf, input int of);
        logic [31:0] w;
        w = '0;
        w[20]    = en;
        w[19:10] = gf[9:0];
        w[9:0]   = of[9:0];
        return w;
    endfunction

    function automatic longint model(input int r, input logic [31:0] w);
        longint oc, gc, d;
        if (w[20]) begin
            oc = longint'(w[9:0]) - 512;
            gc = longint'(w[19:10]) - 512;
        end else begin
            oc = 0;
            gc = 0;
        end
        d = longint'(r) - oc;
        if (d < 0) return 0;
        return (d * 1500000) / (4096 + gc);
    endfunction

    task automatic chk(input string req, input longint act, input longint expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && done) begin
            chk("R6 done pulse width", longint'(prev_done), 0);
            if (exp_q.size() == 0) begin
                chk("R7 unexpected result", 1, 0);
            end else begin
                last_exp = exp_q.pop_front();
                chk(tag_q.pop_front(), longint'(result), last_exp);
            end
        end
        prev_done = rst ? 1'b0 : done;
    end

    task automatic launch(input int r, input logic [31:0] w, input string tag);
        @(negedge clk);
        while (busy) @(negedge clk);
        raw   = r[11:0];
        cal   = w;
        start = 1'b1;
        if (!cap_ok) begin
            cap_word = w;
            cap_ok   = 1'b1;
        end
        exp_q.push_back(model(r, cap_word));
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic conv(input int r, input logic [31:0] w, input string tag);
        launch(r, w, tag);
        drain();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        start = 1'b0;
        exp_q.delete();
        tag_q.delete();
        cap_ok = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 busy in reset", longint'(busy), 0);
        chk("R8 done in reset", longint'(done), 0);
        chk("R8 result in reset", longint'(result), 0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();

        // R2: enable clear, fields full of ones are ignored
        conv(0,    mkcal(1'b0, 1023, 1023), "R2 raw 0 no trim");
        conv(4095, mkcal(1'b0, 1023, 1023), "R2 raw 4095 no trim");
        conv(1234, mkcal(1'b0, 1023, 1023), "R4 raw 1234 no trim");
        // R3: a new enabled word is not taken
        conv(1000, mkcal(1'b1, 0, 1023), "R3 word change ignored");
        // R6: result held while idle
        repeat (5) @(negedge clk);
        chk("R6 result held", longint'(result), last_exp);

        // R1 R4 R5: offset +100, gain -300
        do_reset();
        conv(4095, mkcal(1'b1, 212, 612), "R4 trimmed full code");
        conv(50,   mkcal(1'b1, 0, 0),     "R5 below offset saturates");
        conv(100,  mkcal(1'b1, 0, 0),     "R5 equal to offset");
        conv(2000, mkcal(1'b1, 0, 0),     "R1 trimmed mid code");

        // R7: start while busy dropped
        launch(3000, mkcal(1'b1, 0, 0), "R7 running conversion");
        repeat (10) @(negedge clk);
        raw   = 12'd7;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        drain();
        repeat (60) @(negedge clk);
        chk("R7 busy low after run", longint'(busy), 0);
        chk("R7 result kept", longint'(result), last_exp);

        // R8: reset in the middle of a division, then recapture
        launch(500, mkcal(1'b1, 0, 0), "R8 aborted");
        repeat (10) @(negedge clk);
        do_reset();
        conv(4095, mkcal(1'b1, 1023, 0), "R8 recapture extreme trims");
        conv(0,    mkcal(1'b0, 0, 0),    "R1 negative offset raw 0");

        // R5: largest positive offset
        do_reset();
        conv(510, mkcal(1'b1, 512, 1023), "R5 below max offset");
        conv(511, mkcal(1'b1, 512, 1023), "R5 at max offset");
        conv(512, mkcal(1'b1, 512, 1023), "R1 one step above offset");
        conv(4095, mkcal(1'b1, 0, 0),     "R4 gain field 512 neutral");

        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule